// File: doc/BRIEF.md
# Qualified Falling-Edge Hold Detector

This block watches two single-bit control inputs, `a_in` and `b_in`, and raises `hold_out` when `b_in` drops from 1 to 0 while `a_in` stays at 1. The flag then holds only while that exact pair, `a_in`=1 and `b_in`=0, is kept. Any movement on either input clears it. It comes back only after a fresh qualifying fall of `b_in`. The order in which the inputs change decides the outcome. Arriving at the same pair by raising `a_in` while `b_in` is already low does nothing.

Both inputs may come from another clock domain, so each passes through a two-flop synchronizer. A register keeps the previous synchronized sample, and each edge decision compares the current sample with it. A small Moore machine with four two-bit codes holds the result. The output is a flop of its own, so there is no combinational path from the inputs.

Top module: `ehd_top`

## Requirements
- R1: While `rst` is high at a clock edge, the machine goes to idle and `hold_out` reads 0 after that edge. The synchronizers and the previous-sample register are also cleared.
- R2: A 1-to-0 change of `b_in` while `a_in` is held at 1 drives `hold_out` to 1 exactly three rising edges after the input change: two synchronizer stages plus one state update. After one and after two edges it is still 0.
- R3: As long as `a_in`=1 and `b_in`=0 are both held, `hold_out` stays 1.
- R4: While `hold_out` is 1, a change of `b_in` to 1, or of `a_in` to 0, clears `hold_out` three edges after the change.
- R5: Once cleared, `hold_out` rises again only after a new 1-to-0 fall of `b_in` with `a_in` at 1.
- R6: Reaching `a_in`=1, `b_in`=0 because `a_in` rises while `b_in` is already 0 leaves `hold_out` at 0.
- R7: If both inputs change between two consecutive synchronized samples, no set takes place, and `hold_out` goes or stays low.
- R8: `hold_out` is registered. It changes only at rising clock edges and is 1 exactly when the machine is in its active state.
- R9: The state codes are idle=00, armed (both inputs 1)=01, active=11 and spare=10. Active exits to armed when `b_in` rises back. Any other exit goes through spare for one cycle, and spare always moves to idle on the next clock. The spare pass does not lose a qualifying fall that follows at once, even when the samples run 0x, then 11, then 10 on consecutive cycles.
- R10: The first synchronized sample after reset is never treated as an edge. A fall of `b_in` whose 1-level was seen only before reset does not set `hold_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Qualifier input; must be 1 for a fall of `b_in` to count |
| b_in | input | 1 | Trigger input; its 1-to-0 fall sets the output |
| hold_out | output | 1 | Registered flag: high while the qualified pair is held after a qualifying fall |

## Verification
The assertions assume that the synchronized sample pair is the only thing the machine reacts to. They reason about one sample step at a time, so they take for granted that each input moves at most once per clock. The stimulus drives both inputs only at falling clock edges, which keeps each change to a single sample. A change of both inputs in one sample is produced on purpose, by driving both at the same falling edge. Reset is applied only at falling edges, so each reset pulse covers whole clock cycles.

// File: rtl/ehd_pkg.sv
package ehd_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int PAIR_W      = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMED  = 2'b01,
        ST_ACTIVE = 2'b11,
        ST_SPARE  = 2'b10
    } ehd_state_e;

    typedef struct packed {
        logic a;
        logic b;
    } ehd_pair_t;

    // Qualifying event: A held at 1 across the step while B goes 1 -> 0.
    function automatic logic qual_fall(ehd_pair_t prv, ehd_pair_t cur, logic vld);
        return vld & prv.a & cur.a & prv.b & ~cur.b;
    endfunction

    function automatic logic pair_is_hold(ehd_pair_t p);
        return p.a & ~p.b;
    endfunction

    function automatic logic pair_is_arm(ehd_pair_t p);
        return p.a & p.b;
    endfunction

    function automatic ehd_state_e next_state(ehd_state_e st, ehd_pair_t prv,
                                              ehd_pair_t cur, logic vld);
        ehd_state_e nx;
        nx = ST_IDLE;
        case (st)
            ST_SPARE: nx = ST_IDLE;
            ST_ACTIVE: begin
                if (pair_is_hold(cur))     nx = ST_ACTIVE;
                else if (pair_is_arm(cur)) nx = ST_ARMED;
                else                       nx = ST_SPARE;
            end
            default: begin
                if (qual_fall(prv, cur, vld)) nx = ST_ACTIVE;
                else if (pair_is_arm(cur))    nx = ST_ARMED;
                else                          nx = ST_IDLE;
            end
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/ehd_sync.sv
module ehd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[LAST];
endmodule

// File: rtl/ehd_history.sv
module ehd_history
    import ehd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ehd_pair_t cur,
    output ehd_pair_t prev,
    output logic      vld
);
    ehd_pair_t prev_q;
    logic      vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            prev_q <= cur;
            vld_q  <= 1'b1;
        end
    end

    assign prev = prev_q;
    assign vld  = vld_q;
endmodule

// File: rtl/ehd_fsm.sv
module ehd_fsm
    import ehd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ehd_pair_t  cur,
    input  ehd_pair_t  prev,
    input  logic       vld,
    output ehd_state_e state,
    output logic       flag
);
    ehd_state_e state_q, state_d;
    logic       flag_q;

    always_comb begin
        state_d = next_state(state_q, prev, cur, vld);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= (state_d == ST_ACTIVE);
        end
    end

    assign state = state_q;
    assign flag  = flag_q;
endmodule

// File: rtl/ehd_top.sv
module ehd_top
    import ehd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_in,
    input  logic b_in,
    output logic hold_out
);
    logic [PAIR_W-1:0] sync_raw;
    ehd_pair_t         cur_s;
    ehd_pair_t         prev_s;
    logic              vld_s;
    ehd_state_e        state_s;

    ehd_sync #(
        .WIDTH  (PAIR_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({a_in, b_in}),
        .q_out (sync_raw)
    );

    assign cur_s = ehd_pair_t'(sync_raw);

    ehd_history hist_i (
        .clk  (clk),
        .rst  (rst),
        .cur  (cur_s),
        .prev (prev_s),
        .vld  (vld_s)
    );

    ehd_fsm fsm_i (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur_s),
        .prev  (prev_s),
        .vld   (vld_s),
        .state (state_s),
        .flag  (hold_out)
    );
endmodule

// File: rtl/ehd_checker.sv
module ehd_checker
    import ehd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input ehd_pair_t  cur,
    input ehd_pair_t  prev,
    input logic       vld,
    input ehd_state_e state,
    input logic       x
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && !x && !vld));

    assert_set_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        (vld && prev.a && prev.b && cur.a && !cur.b) |=> x);

    assert_hold_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (x && cur.a && !cur.b) |=> x);

    assert_clear_on_move_R4: assert property (@(posedge clk) disable iff (rst)
        (x && !(cur.a && !cur.b)) |=> !x);

    assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (rst)
        (!x && !(vld && prev.a && prev.b && cur.a && !cur.b)) |=> !x);

    assert_both_moved_R7: assert property (@(posedge clk) disable iff (rst)
        (vld && (prev.a != cur.a) && (prev.b != cur.b)) |=> !x);

    assert_flag_matches_state_R8: assert property (@(posedge clk) disable iff (rst)
        x == (state == ST_ACTIVE));

    assert_spare_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SPARE) |=> (state == ST_IDLE));

    assert_active_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE) |=> (state != ST_IDLE));
endmodule

bind ehd_top ehd_checker chk_i (
    .clk   (clk),
    .rst   (rst),
    .cur   (cur_s),
    .prev  (prev_s),
    .vld   (vld_s),
    .state (state_s),
    .x     (hold_out)
);

// File: tb/ehd_top_tb_top.sv
module ehd_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_CYC   = 4;
    localparam int NVEC       = 21;

    // each entry: {a, b, expected hold_out after HOLD_CYC cycles}, requirement in comment
    localparam logic [2:0] VEC [NVEC] = '{
        3'b000, // R1 idle
        3'b100, // R6 A rises, B low
        3'b110, // R5 arm
        3'b101, // R2 qualifying fall
        3'b101, // R3 held
        3'b110, // R4 B rises
        3'b101, // R5 new fall
        3'b000, // R4 A drops
        3'b100, // R6 A rises, B low
        3'b110, // arm
        3'b000, // R7 both fall
        3'b010, // B only
        3'b100, // R7 both swap
        3'b110, // arm
        3'b101, // R2 fall
        3'b010, // R7 both swap while active
        3'b110, // arm
        3'b010, // A falls, B high
        3'b000, // B falls with A low
        3'b110, // arm
        3'b101  // R5 fall
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic hold_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ehd_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .b_in     (b_in),
        .hold_out (hold_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: hold_out=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic a, input logic b);
        a_in = a;
        b_in = b;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_neg(3);
        check(hold_out, 1'b0, "R1 during reset");
        rst = 1'b0;
        wait_neg(2);
        check(hold_out, 1'b0, "R1 after reset");

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][2], VEC[k][1]);
            wait_neg(HOLD_CYC);
            check(hold_out, VEC[k][0], $sformatf("R2-table row %0d", k));
        end

        // R8 + R2: exact latency, no combinational path
        drive(1'b1, 1'b1);
        wait_neg(HOLD_CYC);
        drive(1'b1, 1'b0);
        #1 check(hold_out, 1'b0, "R8 no comb path");
        wait_neg(1);
        check(hold_out, 1'b0, "R2 after one edge");
        wait_neg(1);
        check(hold_out, 1'b0, "R2 after two edges");
        wait_neg(1);
        check(hold_out, 1'b1, "R2 after three edges");
        drive(1'b0, 1'b0);
        #1 check(hold_out, 1'b1, "R8 holds between edges");
        wait_neg(2);
        check(hold_out, 1'b1, "R4 two edges after drop");
        wait_neg(1);
        check(hold_out, 1'b0, "R4 three edges after drop");

        // R9: quick exit through spare, then arm and fall back to back
        drive(1'b1, 1'b1);
        wait_neg(HOLD_CYC);
        drive(1'b1, 1'b0);
        wait_neg(HOLD_CYC);
        check(hold_out, 1'b1, "R9 setup active");
        drive(1'b0, 1'b0);
        wait_neg(1);
        drive(1'b1, 1'b1);
        wait_neg(1);
        drive(1'b1, 1'b0);
        wait_neg(1);
        check(hold_out, 1'b0, "R9 spare pass clears");
        wait_neg(HOLD_CYC);
        check(hold_out, 1'b1, "R9 fall after spare pass");

        // R1: reset while active
        rst = 1'b1;
        wait_neg(1);
        check(hold_out, 1'b0, "R1 reset while active");
        rst = 1'b0;
        wait_neg(6);
        check(hold_out, 1'b0, "R10 held pair after reset");

        // R10: B level 1 seen only before reset
        drive(1'b1, 1'b1);
        wait_neg(HOLD_CYC);
        rst = 1'b1;
        wait_neg(1);
        rst = 1'b0;
        drive(1'b1, 1'b0);
        wait_neg(HOLD_CYC + 2);
        check(hold_out, 1'b0, "R10 fall across reset");

        // R5: normal fall after reset works
        drive(1'b1, 1'b1);
        wait_neg(HOLD_CYC);
        drive(1'b1, 1'b0);
        wait_neg(HOLD_CYC);
        check(hold_out, 1'b1, "R5 rearm after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule